// File: doc/BRIEF.md
# Interrupt Status and MSI Aggregator

This block collects the interrupt sources of a link controller into sticky status registers and merges them into one interrupt line. Legacy interrupt assert and deassert pulses, a set of general core events, a power-state change and a flush event are each latched into a status register. Each status register has a mask register beside it, and software clears status bits by writing ones to them. Message-signalled interrupts arrive already decoded as a valid strobe with a vector number and a payload. Each one sets a bit in a vector status register, and its payload is kept in a capture register.

Summarising happens in two levels. The core level merges unmasked core and auxiliary status into a summary. That summary sets one bit of a host status register. The unmasked host status bits drive the single interrupt output. A pending-message bit in the core status register is set again on every cycle while any unmasked vector status bit remains, so one pending message cannot be lost by clearing the summary too early. Two plain registers hold the low and high halves of the address that devices send their messages to.

Register map (word addresses on the 4-bit address): 0x0 core status, 0x1 core mask, 0x2 auxiliary status, 0x3 auxiliary mask, 0x4 vector status, 0x5 vector mask, 0x6 payload capture (read-only), 0x7 message address low, 0x8 message address high, 0x9 host status, 0xA host mask.

Top module: `irq_agg`

## Requirements
- R1: In core status (0x0), bit 16+i latches an assert pulse of legacy line i and bit 20+i latches a deassert pulse of line i, for i from 0 to 3. Each bit n of `core_evt_i` latches into bit n. Bits 31 to 27 always read 0.
- R2: Writing a 1 to a bit of core status (0x0), auxiliary status (0x2), vector status (0x4) or host status (0x9) clears that bit at the next edge. A 0 leaves the bit unchanged. If a set and a clear hit the same bit on the same edge, the set wins.
- R3: A cycle with `msi_valid_i` high sets bit `msi_vector_i` of vector status (0x4) and stores `msi_payload_i` in the capture register (0x6). The capture happens whatever the vector mask holds.
- R4: Core status bit 24 is set at every edge where vector status ANDed with the inverse of the vector mask (0x5) is non-zero. A write-1 clear of bit 24 only takes effect once no unmasked vector is pending.
- R5: A mask bit at 1 blocks the matching status bit from every summary. Only valid bits are stored: core mask 26..0, auxiliary mask 5..4, vector mask 31..0, host mask `0x00FFF0FB`.
- R6: In auxiliary status (0x2), bit 4 latches `pwr_chg_i` and bit 5 latches `flush_i`. All other bits read 0.
- R7: Host status (0x9) bit 16 is set one edge after the core summary is high. The core summary is the OR of unmasked core and auxiliary status. Each other bit of `host_evt_i` inside `0x00FFF0FB` latches into the same host bit. Bits outside that pattern read 0.
- R8: `irq_o` is high exactly when some host status bit is set and its host mask bit is 0.
- R9: Addresses 0x7 and 0x8 are plain 32-bit read/write registers holding the message address low and high halves.
- R10: After reset all status registers, the capture register and both address registers are 0. The core, auxiliary and host masks hold all their valid bits, the vector mask is 0, `irq_o` is low, and unmapped addresses (0xB to 0xF) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| core_evt_i | input | 27 | General core event pulses, one per core status bit |
| intx_assert_i | input | 4 | Legacy line assert pulses |
| intx_deassert_i | input | 4 | Legacy line deassert pulses |
| pwr_chg_i | input | 1 | Power-state change pulse |
| flush_i | input | 1 | Flush event pulse |
| host_evt_i | input | 24 | Other host-level event pulses |
| msi_valid_i | input | 1 | Decoded message strobe |
| msi_vector_i | input | 5 | Vector number of the message |
| msi_payload_i | input | 32 | Payload of the message |
| irq_o | output | 1 | Merged interrupt output |

## Verification
The bench builds the block with its default 32 vectors and a 32-bit payload. Every bit of vector status and vector mask can therefore be reached, and a set vector can be written back as a full-word clear. Each cycle a behavioural model is compared against all thirteen readable addresses and the interrupt line, under random writes, masks and event pulses. Before the random phase, directed sequences cover the set-over-clear race on the pending bit and the one-edge delay from core summary to host bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CORE_STAT = 4'h0;
    localparam logic [ADDR_W-1:0] A_CORE_MASK = 4'h1;
    localparam logic [ADDR_W-1:0] A_AUX_STAT  = 4'h2;
    localparam logic [ADDR_W-1:0] A_AUX_MASK  = 4'h3;
    localparam logic [ADDR_W-1:0] A_VEC_STAT  = 4'h4;
    localparam logic [ADDR_W-1:0] A_VEC_MASK  = 4'h5;
    localparam logic [ADDR_W-1:0] A_PAYLOAD   = 4'h6;
    localparam logic [ADDR_W-1:0] A_MADDR_LO  = 4'h7;
    localparam logic [ADDR_W-1:0] A_MADDR_HI  = 4'h8;
    localparam logic [ADDR_W-1:0] A_HOST_STAT = 4'h9;
    localparam logic [ADDR_W-1:0] A_HOST_MASK = 4'hA;

    localparam logic [DATA_W-1:0] CORE_VALID = 32'h07FF_FFFF;
    localparam logic [DATA_W-1:0] AUX_VALID  = 32'h0000_0030;
    localparam logic [DATA_W-1:0] HOST_VALID = 32'h00FF_F0FB;

    localparam int LEGACY_N      = 4;
    localparam int INTX_SET_LSB  = 16;
    localparam int INTX_CLR_LSB  = 20;
    localparam int PEND_BIT      = 24;
    localparam int PWR_BIT       = 4;
    localparam int FLUSH_BIT     = 5;
    localparam int HOST_SUM_BIT  = 16;
    localparam int CORE_EVT_W    = 27;
    localparam int HOST_EVT_W    = 24;
endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
    parameter int          W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr) | set) & VALID;
    end
endmodule

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST & VALID;
        else if (we) q <= d & VALID;
    end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int MSI_VECTORS = 32,
    parameter int PAYLOAD_W   = 32,
    localparam int VEC_W      = $clog2(MSI_VECTORS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [CORE_EVT_W-1:0] core_evt_i,
    input  logic [LEGACY_N-1:0]   intx_assert_i,
    input  logic [LEGACY_N-1:0]   intx_deassert_i,
    input  logic                  pwr_chg_i,
    input  logic                  flush_i,
    input  logic [HOST_EVT_W-1:0] host_evt_i,
    input  logic                  msi_valid_i,
    input  logic [VEC_W-1:0]      msi_vector_i,
    input  logic [PAYLOAD_W-1:0]  msi_payload_i,
    output logic                  irq_o
);
    // write-1-to-clear vectors, one per status register
    function automatic logic [DATA_W-1:0] clr_of(logic [ADDR_W-1:0] a);
        return (wr_en && wr_addr == a) ? wr_data : '0;
    endfunction

    logic [DATA_W-1:0]      core_q, core_mask_q, aux_q, aux_mask_q;
    logic [DATA_W-1:0]      host_q, host_mask_q, maddr_lo_q, maddr_hi_q;
    logic [MSI_VECTORS-1:0] msi_q, msi_mask_q, msi_set;
    logic [PAYLOAD_W-1:0]   payload_q;
    logic [DATA_W-1:0]      core_set, aux_set, host_set;
    logic [DATA_W-1:0]      clr_core, clr_aux, clr_vec, clr_host;
    logic                   msi_pend, core_sum;

    assign clr_core = clr_of(A_CORE_STAT);
    assign clr_aux  = clr_of(A_AUX_STAT);
    assign clr_vec  = clr_of(A_VEC_STAT);
    assign clr_host = clr_of(A_HOST_STAT);

    // first level: core and auxiliary summary
    assign msi_pend = |(msi_q & ~msi_mask_q);
    assign core_sum = (|(core_q & ~core_mask_q)) | (|(aux_q & ~aux_mask_q));

    assign core_set = DATA_W'(core_evt_i)
                    | (DATA_W'(intx_assert_i)   << INTX_SET_LSB)
                    | (DATA_W'(intx_deassert_i) << INTX_CLR_LSB)
                    | (DATA_W'(msi_pend)        << PEND_BIT);
    assign aux_set  = (DATA_W'(pwr_chg_i) << PWR_BIT) | (DATA_W'(flush_i) << FLUSH_BIT);
    assign host_set = (DATA_W'(host_evt_i) & ~(DATA_W'(1) << HOST_SUM_BIT))
                    | (DATA_W'(core_sum) << HOST_SUM_BIT);

    always_comb begin
        msi_set = '0;
        if (msi_valid_i) msi_set[msi_vector_i] = 1'b1;
    end

    irq_w1c_reg #(.W(DATA_W), .VALID(CORE_VALID)) u_core_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_core), .set(core_set), .q(core_q));
    irq_w1c_reg #(.W(DATA_W), .VALID(AUX_VALID)) u_aux_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_aux), .set(aux_set), .q(aux_q));
    irq_w1c_reg #(.W(MSI_VECTORS), .VALID('1)) u_vec_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_vec[MSI_VECTORS-1:0]), .set(msi_set), .q(msi_q));
    irq_w1c_reg #(.W(DATA_W), .VALID(HOST_VALID)) u_host_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_host), .set(host_set), .q(host_q));

    irq_rw_reg #(.W(DATA_W), .VALID(CORE_VALID), .RST(CORE_VALID)) u_core_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_CORE_MASK), .d(wr_data), .q(core_mask_q));
    irq_rw_reg #(.W(DATA_W), .VALID(AUX_VALID), .RST(AUX_VALID)) u_aux_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_AUX_MASK), .d(wr_data), .q(aux_mask_q));
    irq_rw_reg #(.W(MSI_VECTORS), .VALID('1), .RST('0)) u_vec_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_VEC_MASK),
        .d(wr_data[MSI_VECTORS-1:0]), .q(msi_mask_q));
    irq_rw_reg #(.W(DATA_W), .VALID(HOST_VALID), .RST(HOST_VALID)) u_host_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_HOST_MASK), .d(wr_data), .q(host_mask_q));
    irq_rw_reg #(.W(DATA_W), .VALID('1), .RST('0)) u_maddr_lo (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_MADDR_LO), .d(wr_data), .q(maddr_lo_q));
    irq_rw_reg #(.W(DATA_W), .VALID('1), .RST('0)) u_maddr_hi (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_addr == A_MADDR_HI), .d(wr_data), .q(maddr_hi_q));
    irq_rw_reg #(.W(PAYLOAD_W), .VALID('1), .RST('0)) u_payload (
        .clk(clk), .rst_n(rst_n), .we(msi_valid_i), .d(msi_payload_i), .q(payload_q));

    // second level: host status drives the line
    assign irq_o = |(host_q & ~host_mask_q);

    always_comb begin
        unique case (rd_addr)
            A_CORE_STAT: rd_data = core_q;
            A_CORE_MASK: rd_data = core_mask_q;
            A_AUX_STAT:  rd_data = aux_q;
            A_AUX_MASK:  rd_data = aux_mask_q;
            A_VEC_STAT:  rd_data = DATA_W'(msi_q);
            A_VEC_MASK:  rd_data = DATA_W'(msi_mask_q);
            A_PAYLOAD:   rd_data = DATA_W'(payload_q);
            A_MADDR_LO:  rd_data = maddr_lo_q;
            A_MADDR_HI:  rd_data = maddr_hi_q;
            A_HOST_STAT: rd_data = host_q;
            A_HOST_MASK: rd_data = host_mask_q;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int MSI_VECTORS = 32,
    parameter int PAYLOAD_W   = 32,
    localparam int VEC_W      = $clog2(MSI_VECTORS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msi_valid_i,
    input logic [VEC_W-1:0]       msi_vector_i,
    input logic [PAYLOAD_W-1:0]   msi_payload_i,
    input logic [LEGACY_N-1:0]    intx_assert_i,
    input logic                   irq_o,
    input logic                   core_sum,
    input logic [DATA_W-1:0]      core_q,
    input logic [DATA_W-1:0]      host_q,
    input logic [DATA_W-1:0]      host_mask_q,
    input logic [MSI_VECTORS-1:0] msi_q,
    input logic [MSI_VECTORS-1:0] msi_mask_q,
    input logic [PAYLOAD_W-1:0]   payload_q
);
    AST_INTX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_assert_i != '0) |=> ((core_q[INTX_SET_LSB +: LEGACY_N] & $past(intx_assert_i)) == $past(intx_assert_i))); // R1
    AST_CORE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        core_q[DATA_W-1:CORE_EVT_W] == '0); // R1
    AST_VECTOR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid_i |=> msi_q[$past(msi_vector_i)]); // R3
    AST_PAYLOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid_i |=> (payload_q == $past(msi_payload_i))); // R3
    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((msi_q & ~msi_mask_q) != '0) |=> core_q[PEND_BIT]); // R4
    AST_SUMMARY_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        core_sum |=> host_q[HOST_SUM_BIT]); // R7
    AST_LINE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mask_q == HOST_VALID) |-> !irq_o); // R8
endmodule

bind irq_agg irq_agg_chk #(.MSI_VECTORS(MSI_VECTORS), .PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_valid_i(msi_valid_i), .msi_vector_i(msi_vector_i),
    .msi_payload_i(msi_payload_i), .intx_assert_i(intx_assert_i), .irq_o(irq_o),
    .core_sum(core_sum), .core_q(core_q), .host_q(host_q), .host_mask_q(host_mask_q),
    .msi_q(msi_q), .msi_mask_q(msi_mask_q), .payload_q(payload_q));

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
    localparam int CLK_PERIOD = 40;
    localparam logic [31:0] CV = 32'h07FF_FFFF;
    localparam logic [31:0] AV = 32'h0000_0030;
    localparam logic [31:0] HV = 32'h00FF_F0FB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [26:0] core_evt_i = '0;
    logic [3:0]  intx_assert_i = '0;
    logic [3:0]  intx_deassert_i = '0;
    logic        pwr_chg_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [23:0] host_evt_i = '0;
    logic        msi_valid_i = 1'b0;
    logic [4:0]  msi_vector_i = '0;
    logic [31:0] msi_payload_i = '0;
    logic        irq_o;

    int n_vec = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_evt_i(core_evt_i),
        .intx_assert_i(intx_assert_i), .intx_deassert_i(intx_deassert_i),
        .pwr_chg_i(pwr_chg_i), .flush_i(flush_i), .host_evt_i(host_evt_i),
        .msi_valid_i(msi_valid_i), .msi_vector_i(msi_vector_i),
        .msi_payload_i(msi_payload_i), .irq_o(irq_o));

    // behavioural reference model
    logic [31:0] m_core, m_cmask, m_aux, m_amask, m_vec, m_vmask;
    logic [31:0] m_pay, m_lo, m_hi, m_host, m_hmask;

    function automatic logic [31:0] wclr(int a);
        return (wr_en && int'(wr_addr) == a) ? wr_data : 32'h0;
    endfunction

    function automatic logic wsel(int a);
        return wr_en && int'(wr_addr) == a;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_core <= 0; m_aux <= 0; m_vec <= 0; m_host <= 0;
            m_pay <= 0; m_lo <= 0; m_hi <= 0;
            m_cmask <= CV; m_amask <= AV; m_vmask <= 0; m_hmask <= HV;
        end else begin
            bit pend, csum;
            logic [31:0] vset;
            pend = (m_vec & ~m_vmask) != 0;
            csum = ((m_core & ~m_cmask) != 0) || ((m_aux & ~m_amask) != 0);
            vset = msi_valid_i ? (32'h1 << msi_vector_i) : 32'h0;
            m_core <= ((m_core & ~wclr(0)) | 32'(core_evt_i) | (32'(intx_assert_i) << 16)
                       | (32'(intx_deassert_i) << 20) | (32'(pend) << 24)) & CV;
            m_aux  <= ((m_aux & ~wclr(2)) | (32'(pwr_chg_i) << 4) | (32'(flush_i) << 5)) & AV;
            m_vec  <= (m_vec & ~wclr(4)) | vset;
            m_host <= ((m_host & ~wclr(9)) | (32'(host_evt_i) & ~32'h0001_0000)
                       | (32'(csum) << 16)) & HV;
            if (wsel(1))  m_cmask <= wr_data & CV;
            if (wsel(3))  m_amask <= wr_data & AV;
            if (wsel(5))  m_vmask <= wr_data;
            if (wsel(7))  m_lo    <= wr_data;
            if (wsel(8))  m_hi    <= wr_data;
            if (wsel(10)) m_hmask <= wr_data & HV;
            if (msi_valid_i) m_pay <= msi_payload_i;
        end
    end

    function automatic logic [31:0] m_read(int a);
        case (a)
            0: return m_core;  1: return m_cmask; 2: return m_aux;   3: return m_amask;
            4: return m_vec;   5: return m_vmask; 6: return m_pay;   7: return m_lo;
            8: return m_hi;    9: return m_host;  10: return m_hmask;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R1"; 2: return "R6"; 4, 6: return "R3"; 7, 8: return "R9";
            9: return "R7"; 1, 3, 5, 10: return "R5"; default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string tag);
        rd_addr = 4'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    // one clock: apply driven inputs, then compare everything against the model
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("R8", 32'(irq_o), 32'(((m_host & ~m_hmask) != 0)));
        for (int a = 0; a < 13; a++) rd_chk(a, m_read(a), tag_of(a));
        wr_en = 0; core_evt_i = 0; intx_assert_i = 0; intx_deassert_i = 0;
        pwr_chg_i = 0; flush_i = 0; host_evt_i = 0; msi_valid_i = 0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        tick();
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", 32'(irq_o), 32'h0);
        rd_chk(0, 32'h0, "R10");
        rd_chk(1, CV, "R10");
        rd_chk(3, AV, "R10");
        rd_chk(5, 32'h0, "R10");
        rd_chk(10, HV, "R10");
        rd_chk(13, 32'h0, "R10");
        rst_n = 1;
        @(negedge clk);

        // R1: assert pulse of legacy line 2
        intx_assert_i = 4'b0100; tick();
        rd_chk(0, 32'h0004_0000, "R1");
        intx_deassert_i = 4'b0001; tick();
        rd_chk(0, 32'h0014_0000, "R1");
        // R2: write-1 clears only the written bit
        wr(0, 32'h0004_0000);
        rd_chk(0, 32'h0010_0000, "R2");
        wr(0, 32'h0010_0000);
        // R6: flush event
        flush_i = 1; tick();
        rd_chk(2, 32'h0000_0020, "R6");
        // R5/R7/R8: unmask flush, then host summary bit
        wr(3, 32'h0000_0010);
        wr(10, 32'h00FE_F0FB);
        rd_chk(9, 32'h0001_0000, "R7");
        chk("R8", 32'(irq_o), 32'h1);
        wr(2, 32'h0000_0020);
        wr(9, 32'h0001_0000);
        rd_chk(9, 32'h0, "R2");
        chk("R8", 32'(irq_o), 32'h0);
        // R3: message capture
        msi_valid_i = 1; msi_vector_i = 5'd7; msi_payload_i = 32'h0000_00A5; tick();
        rd_chk(4, 32'h0000_0080, "R3");
        rd_chk(6, 32'h0000_00A5, "R3");
        tick();
        rd_chk(0, 32'h0100_0000, "R4");
        wr(0, 32'h0100_0000);
        rd_chk(0, 32'h0100_0000, "R4");
        wr(4, 32'h0000_0080);
        wr(0, 32'h0100_0000);
        rd_chk(0, 32'h0, "R4");
        // R9: message address
        wr(7, 32'hDEAD_BEEF);
        wr(8, 32'h1234_5678);
        rd_chk(7, 32'hDEAD_BEEF, "R9");
        rd_chk(8, 32'h1234_5678, "R9");

        // random phase, model compared each cycle
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                wr_en = 1; wr_addr = 4'($urandom_range(0, 12)); wr_data = $urandom;
            end
            core_evt_i      = 27'($urandom & $urandom & $urandom);
            intx_assert_i   = 4'($urandom & $urandom);
            intx_deassert_i = 4'($urandom & $urandom);
            pwr_chg_i       = ($urandom_range(0, 7) == 0);
            flush_i         = ($urandom_range(0, 7) == 0);
            host_evt_i      = 24'($urandom & $urandom & $urandom);
            msi_valid_i     = ($urandom_range(0, 3) == 0);
            msi_vector_i    = 5'($urandom);
            msi_payload_i   = $urandom;
            tick();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule